// File: doc/BRIEF.md
# Bus Machine-Cycle T-State Sequencer

This block produces the clock-by-clock state sequence for one bus machine cycle of a small 8-bit processor. A client raises a request that gives the cycle kind, a 16-bit address, a write byte and a count of trailing internal clocks. There are three cycle kinds: opcode fetch, memory read and memory write. The sequencer then walks the T states. It puts the low address byte on a shared address/data bus and pulses the latch enable. It drives an active-low read or write strobe. It holds the transfer open for as long as the addressed device pulls READY low. A read byte is captured from the shared bus when the transfer completes.

An opcode fetch adds one decode state after the transfer. Any cycle can be followed by a programmed run of quiet internal states, which model operations that need extra clocks after their bus traffic. A status output exposes the current T state, so the clocks of a cycle can be counted from outside. A done flag marks the final state of each cycle. A new request may be taken in that same clock, so cycles can run back to back without an idle gap.

Top module: `bus_tstate_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no request, state_o is 0 (idle), ale_o and ad_oe_o are low, rd_no and wr_no are high and done_o is low.
- R2: The first state of a cycle (T1, state_o=1) lasts exactly one clock. In it ale_o is high, ad_oe_o is high, ad_o carries addr[7:0], a_hi_o carries addr[15:8], and both strobes are high. ale_o is low in every other state.
- R3: For kind 0 (fetch) and kind 1 (read), rd_no is low in T2, in every wait state and in T3, and is high everywhere else. wr_no stays high and ad_oe_o is low in those states. The two strobes are never low together.
- R4: For kind 2 (write), wr_no is low in T2, in every wait state and in T3. In those states ad_oe_o is high and ad_o carries the write byte. rd_no stays high throughout.
- R5: READY is sampled on the edge that ends T2 and on the edge that ends each wait state (state_o=3). Each low sample adds exactly one wait state. The first high sample enters T3 (state_o=4). Wait states appear nowhere else.
- R6: A cycle with w low READY samples and n appended idle states lasts 4+w+n clocks for a fetch and 3+w+n clocks for a read or write, counted from T1 to the done state inclusive.
- R7: A fetch enters T4 (state_o=5) right after T3. In T4 both strobes are high, and ale_o and ad_oe_o are low. Reads and writes never enter T4.
- R8: The idle count given with the request (idle_cnt_i) appends exactly that many internal states (state_o=6) after T3 or T4. In them both strobes are high, and ale_o and ad_oe_o are low.
- R9: For a fetch or read, rdata_o takes the value of ad_i on the edge that ends T3 and holds it afterwards. A write cycle leaves rdata_o unchanged.
- R10: done_o is high in exactly the final state of a cycle. A request is accepted only in idle or in a clock where done_o is high; it then starts T1 on the next clock. A request raised at any other time is ignored. With no request, the state after done is idle.
- R11: state_o encodes idle=0, T1=1, T2=2, wait=3, T3=4, T4=5, internal idle=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Cycle request |
| kind_i | input | 2 | Cycle kind: 0 fetch, 1 read, 2 write |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Byte to store on a write |
| idle_cnt_i | input | 3 | Internal idle states to append |
| ready_i | input | 1 | Device ready; low stretches the transfer |
| ad_i | input | 8 | Shared bus read value |
| ad_o | output | 8 | Shared bus drive value (address low, then data) |
| ad_oe_o | output | 1 | Shared bus output enable |
| a_hi_o | output | 8 | Address high byte |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| state_o | output | 3 | Current T state code |
| rdata_o | output | 8 | Last captured read byte |
| done_o | output | 1 | High in the final state of a cycle |

## Verification
The hardest situation to reach is a cycle that stacks every stretch at once: several wait states, the fetch decode state, a run of idle states, and a new request taken in the done clock. The stimulus computes the expected state for each clock from the cycle kind, wait count and idle count. It releases READY only after the planned number of wait samples. The bench sweeps all kinds with 0 to 3 waits and 0 to 3 idle states, then chains cycles back to back. A stray request is raised during T2 of every cycle to show that it is ignored. The shared bus carries a decoy value outside T3, so a capture at the wrong edge shows up in rdata_o.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5,
    ST_TI   = 3'd6
  } tstate_e;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd2;
endpackage

// File: rtl/seq_req_latch.sv
module seq_req_latch
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDLE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDLE_W-1:0] idle_i,
  output logic              is_fetch_o,
  output logic              is_write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [IDLE_W-1:0] idle_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_fetch_o <= 1'b0;
      is_write_o <= 1'b0;
      addr_o     <= '0;
      wdata_o    <= '0;
      idle_o     <= '0;
    end else if (accept_i) begin
      is_fetch_o <= (kind_i == KIND_FETCH);
      is_write_o <= (kind_i == KIND_WRITE);
      addr_o     <= addr_i;
      wdata_o    <= wdata_i;
      idle_o     <= idle_i;
    end
  end
endmodule

// File: rtl/seq_tstate_fsm.sv
module seq_tstate_fsm
  import bus_seq_pkg::*;
#(
  parameter int IDLE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ready_i,
  input  logic              is_fetch_i,
  input  logic [IDLE_W-1:0] idle_len_i,
  output tstate_e           state_o,
  output logic              done_o,
  output logic              accept_o
);
  localparam logic [IDLE_W-1:0] CNT_ONE = IDLE_W'(1);

  tstate_e           st_q, st_d, st_end;
  logic [IDLE_W-1:0] cnt_q, cnt_d;
  logic              has_idle;

  assign has_idle = (idle_len_i != '0);

  always_comb begin
    done_o = 1'b0;
    unique case (st_q)
      ST_T3:   done_o = !is_fetch_i && !has_idle;
      ST_T4:   done_o = !has_idle;
      ST_TI:   done_o = (cnt_q == CNT_ONE);
      default: done_o = 1'b0;
    endcase
  end

  assign accept_o = req_i && ((st_q == ST_IDLE) || done_o);
  assign st_end   = accept_o ? ST_T1 : ST_IDLE;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: st_d = st_end;
      ST_T1:   st_d = ST_T2;
      ST_T2,
      ST_TW:   st_d = ready_i ? ST_T3 : ST_TW;
      ST_T3: begin
        if (is_fetch_i)    st_d = ST_T4;
        else if (has_idle) begin st_d = ST_TI; cnt_d = idle_len_i; end
        else               st_d = st_end;
      end
      ST_T4: begin
        if (has_idle) begin st_d = ST_TI; cnt_d = idle_len_i; end
        else          st_d = st_end;
      end
      ST_TI: begin
        cnt_d = cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) st_d = st_end;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;

  AST_WAIT_AFTER_T2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TW) |-> (($past(st_q) == ST_T2 || $past(st_q) == ST_TW) && !$past(ready_i))); // R5
  AST_T3_ON_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T3) |-> $past(ready_i)); // R5
  AST_T4_FETCH_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T4) |-> ($past(st_q) == ST_T3 && is_fetch_i)); // R7
  AST_T1_FROM_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T1) |-> $past(accept_o)); // R10
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (st_q == ST_IDLE || st_q == ST_T1)); // R10
endmodule

// File: rtl/seq_bus_drive.sv
module seq_bus_drive
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  tstate_e                  state_i,
  input  logic                     is_write_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] a_hi_o,
  output logic                     ale_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [DATA_W-1:0]        rdata_o
);
  logic xfer;

  always_comb begin
    xfer    = (state_i == ST_T2) || (state_i == ST_TW) || (state_i == ST_T3);
    ale_o   = (state_i == ST_T1);
    rd_no   = !(xfer && !is_write_i);
    wr_no   = !(xfer && is_write_i);
    ad_oe_o = (state_i == ST_T1) || (xfer && is_write_i);
    ad_o    = (state_i == ST_T1) ? addr_i[DATA_W-1:0] : wdata_i;
  end

  assign a_hi_o = addr_i[ADDR_W-1:DATA_W];

  // capture on the edge that closes T3
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             rdata_o <= '0;
    else if (state_i == ST_T3 && !is_write_i) rdata_o <= ad_i;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no)); // R3
  AST_ALE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_TI) |-> (rd_no && wr_no && !ale_o && !ad_oe_o)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) != ST_T3) |-> $stable(rdata_o)); // R9
endmodule

// File: rtl/bus_tstate_seq.sv
module bus_tstate_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDLE_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [1:0]               kind_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [IDLE_W-1:0]        idle_cnt_i,
  input  logic                     ready_i,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] a_hi_o,
  output logic                     ale_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [2:0]               state_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o
);
  logic              accept, is_fetch, is_write;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDLE_W-1:0] idle_q;
  tstate_e           st;

  seq_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDLE_W(IDLE_W)) u_latch (
    .clk_i, .rst_ni, .accept_i(accept), .kind_i, .addr_i, .wdata_i, .idle_i(idle_cnt_i),
    .is_fetch_o(is_fetch), .is_write_o(is_write), .addr_o(addr_q), .wdata_o(wdata_q),
    .idle_o(idle_q)
  );

  seq_tstate_fsm #(.IDLE_W(IDLE_W)) u_fsm (
    .clk_i, .rst_ni, .req_i, .ready_i, .is_fetch_i(is_fetch), .idle_len_i(idle_q),
    .state_o(st), .done_o, .accept_o(accept)
  );

  seq_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk_i, .rst_ni, .state_i(st), .is_write_i(is_write), .addr_i(addr_q),
    .wdata_i(wdata_q), .ad_i, .ad_o, .ad_oe_o, .a_hi_o, .ale_o, .rd_no, .wr_no, .rdata_o
  );

  assign state_o = st;
endmodule

// File: tb/bus_tstate_seq_tb.sv
module bus_tstate_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] S_IDLE = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2, S_TW = 3'd3,
                         S_T3 = 3'd4, S_T4 = 3'd5, S_TI = 3'd6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, ready_i = 1'b1;
  logic [1:0]  kind_i = '0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0, ad_i = '0;
  logic [2:0]  idle_cnt_i = '0;
  logic [7:0]  ad_o, a_hi_o, rdata_o;
  logic        ad_oe_o, ale_o, rd_no, wr_no, done_o;
  logic [2:0]  state_o;

  int checks = 0, errors = 0;
  logic [1:0]  nx_kind;
  logic [15:0] nx_addr;
  logic [7:0]  nx_wdata;
  logic [2:0]  nx_idle;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_tstate_seq u_dut (
    .clk_i(clk), .rst_ni, .req_i, .kind_i, .addr_i, .wdata_i, .idle_cnt_i, .ready_i, .ad_i,
    .ad_o, .ad_oe_o, .a_hi_o, .ale_o, .rd_no, .wr_no, .state_o, .rdata_o, .done_o
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Called at a negedge with state idle, or with state T1 after a chained accept.
  task automatic run_cyc(input int k, input int w, input int n, input logic [15:0] a,
                         input logic [7:0] d, input logic [7:0] rb, input bit chain);
    int exp_len;
    logic [7:0] old_rd;
    bit fin;
    int idx;
    logic [2:0] es;
    bit wr, xf;
    exp_len = ((k == 0) ? 4 : 3) + w + n;
    old_rd = rdata_o;
    fin = 0;
    idx = 0;
    if (state_o == S_IDLE) begin
      req_i = 1'b1; kind_i = 2'(k); addr_i = a; wdata_i = d; idle_cnt_i = 3'(n);
      @(negedge clk);
    end
    while (!fin) begin
      idx++;
      if (idx == 1)                     es = S_T1;
      else if (idx == 2)                es = S_T2;
      else if (idx <= 2 + w)            es = S_TW;
      else if (idx == 3 + w)            es = S_T3;
      else if (k == 0 && idx == 4 + w)  es = S_T4;
      else                              es = S_TI;
      wr = (k == 2);
      xf = (es == S_T2 || es == S_TW || es == S_T3);
      chk(state_o == es, (es == S_TW || es == S_T3) ? "R5" : (es == S_T4 ? "R7" : "R11"),
          "state", state_o, es);
      chk(ale_o == (es == S_T1), "R2", "ale", ale_o, es == S_T1);
      chk(rd_no == !(xf && !wr), "R3", "rd_n", rd_no, !(xf && !wr));
      chk(wr_no == !(xf && wr), "R4", "wr_n", wr_no, !(xf && wr));
      chk(ad_oe_o == ((es == S_T1) || (xf && wr)), (es == S_TI) ? "R8" : "R4", "oe",
          ad_oe_o, (es == S_T1) || (xf && wr));
      if (es == S_T1) begin
        chk(ad_o == a[7:0], "R2", "ad addr", ad_o, a[7:0]);
        chk(a_hi_o == a[15:8], "R2", "a_hi", a_hi_o, a[15:8]);
      end
      if (xf && wr) chk(ad_o == d, "R4", "ad data", ad_o, d);
      chk(done_o == (idx == exp_len), "R6", "done", done_o, idx == exp_len);
      // drive for the coming edge
      ready_i = 1'b1;
      if (es == S_T2 || es == S_TW) ready_i = ((idx - 2) >= w);
      ad_i = (es == S_T3) ? rb : ~rb;
      if (es == S_T2) begin
        req_i = 1'b1; kind_i = 2'd2; addr_i = 16'hFFFF; wdata_i = 8'h5A; idle_cnt_i = 3'd7;
      end else if (idx == exp_len && chain) begin
        req_i = 1'b1; kind_i = nx_kind; addr_i = nx_addr; wdata_i = nx_wdata; idle_cnt_i = nx_idle;
      end else req_i = 1'b0;
      if (idx >= exp_len || idx > 40) fin = 1;
      @(negedge clk);
    end
    req_i = 1'b0;
    ready_i = 1'b1;
    chk(rdata_o == ((k == 2) ? old_rd : rb), "R9", "rdata", rdata_o, (k == 2) ? old_rd : rb);
    chk(state_o == (chain ? S_T1 : S_IDLE), "R10", "after done", state_o, chain ? S_T1 : S_IDLE);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(state_o == S_IDLE, "R1", "reset state", state_o, S_IDLE);
    chk(ale_o == 0 && ad_oe_o == 0 && done_o == 0, "R1", "reset ale/oe/done",
        {ale_o, ad_oe_o, done_o}, 0);
    chk(rd_no && wr_no, "R1", "reset strobes", {rd_no, wr_no}, 3);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(state_o == S_IDLE, "R1", "idle without request", state_o, S_IDLE);

    for (int k = 0; k < 3; k++)
      for (int w = 0; w < 4; w++)
        for (int n = 0; n < 4; n++)
          run_cyc(k, w, n, 16'(16'h1234 + k * 4099 + w * 257 + n * 31),
                  8'(8'h11 * (w + 1) + n), 8'(8'hA0 + k * 16 + w * 4 + n), 1'b0);

    // back-to-back chaining through the done clock (R10)
    nx_kind = 2'd2; nx_addr = 16'hBEEF; nx_wdata = 8'h77; nx_idle = 3'd1;
    run_cyc(0, 1, 2, 16'hC001, 8'h00, 8'h3C, 1'b1);
    nx_kind = 2'd1; nx_addr = 16'h0F0F; nx_wdata = 8'h00; nx_idle = 3'd0;
    run_cyc(2, 0, 1, 16'hBEEF, 8'h77, 8'h00, 1'b1);
    run_cyc(1, 2, 0, 16'h0F0F, 8'h00, 8'hE7, 1'b0);
    run_cyc(0, 0, 7, 16'h8000, 8'h00, 8'h81, 1'b0);

    repeat (2) @(negedge clk);
    chk(state_o == S_IDLE && rd_no && wr_no, "R10", "stays idle", state_o, S_IDLE);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule